// File: doc/BRIEF.md
# Clock-Generator Configuration Target (I2C)

This block is an I2C target that holds a small bank of 8-bit configuration registers for a clock generator. Downstream synthesis logic uses the registers. The bank reaches that logic as one flat parallel output, and every register returns to a fixed default value at reset. A host writes the bank with a block-write transfer. That transfer always carries a command byte and a byte-count byte. The target acknowledges both and discards their values. It then stores the data bytes from register 0 upward, one register per byte.

A block-read returns a byte count first, then every register in ascending order. The block runs entirely on the system clock. It samples SCL and SDA through a synchronizer, finds START, STOP and SCL edges, and pulls SDA low through an output-enable pin, so the pad stays open-drain. It never stretches the clock. It is meant for standard-mode bus rates, which are slow next to the system clock. The bus carries no valid/ready stream at this edge. The host controls pacing completely through SCL, and the only flow control is the ACK/NACK bit.

Top module: `cfgi2c_target`

## Requirements
- R1: After reset, `cfg_o` holds the defaults, with register k at bits [8k+7:8k]: reg0=0x3C, reg1=0xA5, reg2=0xF0, reg3=0x0F, reg4=0x96, reg5=0xC3. `sda_oe` is low.
- R2: The address byte 0xD2 (device 0x69, write) and the address byte 0xD3 (device 0x69, read) are acknowledged. Any other address byte is NACKed, and every following byte is ignored (no ACK, no register change) until the next START.
- R3: In a write, the two bytes after the address are acknowledged and their values are discarded. Data bytes then land in reg0, reg1, … in order, each acknowledged.
- R4: A data byte is committed to its register when its eighth bit is sampled, before its ACK slot ends. A STOP after any complete byte leaves all committed registers in place and the rest unchanged.
- R5: Write data bytes beyond the last register are NACKed and change no register.
- R6: A read returns the byte 0x06 (the register count) and then reg0 through reg5, each MSB first.
- R7: If the host NACKs a read byte, the target keeps SDA released (the host sees all ones) until STOP or START.
- R8: If the host acknowledges reg5 and clocks another byte, the target keeps SDA released.
- R9: A START at any point, including a repeated START in the middle of a transfer, restarts the address phase and releases SDA. A STOP returns the target to idle with SDA released.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | NUM_REGS*8 | All register bytes; register k at bits [8k+7:8k] |

## Verification
The bench builds the block with its defaults:
- six registers;
- device address 0x69;
- a two-stage synchronizer.

With only six registers, every write length from zero bytes up to one byte past the bank is within reach, and so is every position at which the host can NACK a read. The 7-bit address is also small enough to sweep completely in both directions. Expected register contents come from a byte pattern that the bench computes per write length and position. The bench keeps a model of the bank from those computed patterns.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } cfgi2c_state_e;

  localparam logic RW_READ = 1'b1;

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  // stg[STAGES-1] is the synchronized level, stg[STAGES] the previous one
  logic [W-1:0] stg [0:STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~stg[STAGES];
  assign fall = ~stg[STAGES-1] & stg[STAGES];

endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs #(
  parameter int                     N        = 6,
  parameter int                     IW       = 3,
  parameter logic [N*8-1:0]         DEFAULTS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic [N*8-1:0] flat
);

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flat[g*8 +: 8] <= DEFAULTS[g*8 +: 8];
      else if (we && widx == IW'(g))     flat[g*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (ridx == IW'(i)) rdata = flat[i*8 +: 8];
  end

endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target
  import cfgi2c_pkg::*;
#(
  parameter int                      NUM_REGS     = 6,
  parameter logic [6:0]              DEV_ADDR     = 7'h69,
  parameter int                      SYNC_STAGES  = 2,
  parameter logic [NUM_REGS*8-1:0]   REG_DEFAULTS = 48'hC3960FF0A53C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int            PW         = $clog2(NUM_REGS + 4);
  localparam int            IW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0]    COUNT_BYTE = 8'(NUM_REGS);
  localparam logic [PW-1:0] FIRST_DATA = PW'(3);
  localparam logic [PW-1:0] END_DATA   = PW'(NUM_REGS + 3);
  localparam logic [PW-1:0] END_READ   = PW'(NUM_REGS);

  // Bus sampling: bit 1 = SCL, bit 0 = SDA
  logic [1:0] lvl, rse, fal;
  cfgi2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (lvl),
    .rise (rse),
    .fall (fal)
  );

  logic scl_s, sda_s, scl_r, scl_f, start_det, stop_det;
  assign scl_s     = lvl[1];
  assign sda_s     = lvl[0];
  assign scl_r     = rse[1];
  assign scl_f     = fal[1];
  assign start_det = scl_s & fal[0];
  assign stop_det  = scl_s & rse[0];

  cfgi2c_state_e state;
  logic [2:0]    bit_cnt;
  logic [PW-1:0] pos;      // write: 0 addr,1 cmd,2 count,3.. data; read: tx index
  logic [7:0]    shreg, tx_sh;
  logic          ack_q, is_read, oe_q;

  logic [7:0]    rx_byte;
  logic          ack_now, reg_we;
  logic [IW-1:0] reg_widx, reg_ridx;
  logic [7:0]    reg_rdata;

  assign rx_byte = {shreg[6:0], sda_s};

  always_comb begin
    if (pos == '0)               ack_now = (rx_byte[7:1] == DEV_ADDR);
    else if (pos < FIRST_DATA)   ack_now = 1'b1;
    else                         ack_now = (pos < END_DATA);
  end

  assign reg_we   = (state == ST_RX) && scl_r && (bit_cnt == 3'd7) &&
                    (pos >= FIRST_DATA) && (pos < END_DATA);
  assign reg_widx = IW'(pos - FIRST_DATA);
  assign reg_ridx = IW'(pos);

  cfgi2c_regs #(.N(NUM_REGS), .IW(IW), .DEFAULTS(REG_DEFAULTS)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .widx (reg_widx),
    .wdata(rx_byte),
    .ridx (reg_ridx),
    .rdata(reg_rdata),
    .flat (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      pos     <= '0;
      shreg   <= '0;
      tx_sh   <= '0;
      ack_q   <= 1'b0;
      is_read <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      bit_cnt <= '0;
      pos     <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_r) begin
          shreg   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            state <= ST_ACK_WAIT;
            ack_q <= ack_now;
            pos   <= pos + PW'(1);
            if (pos == '0) is_read <= (sda_s == RW_READ);
          end
        end
        ST_ACK_WAIT: if (scl_f) begin
          oe_q  <= ack_q;
          state <= ST_ACK;
        end
        ST_ACK: if (scl_f) begin
          bit_cnt <= '0;
          if (!ack_q) begin
            oe_q  <= 1'b0;
            state <= ST_WAIT;
          end else if (is_read && pos == PW'(1)) begin
            pos   <= '0;
            tx_sh <= COUNT_BYTE;
            oe_q  <= ~COUNT_BYTE[7];
            state <= ST_TX;
          end else begin
            oe_q  <= 1'b0;
            state <= ST_RX;
          end
        end
        ST_TX: if (scl_f) begin
          if (bit_cnt == 3'd7) begin
            oe_q    <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_MACK;
          end else begin
            tx_sh   <= {tx_sh[6:0], 1'b0};
            oe_q    <= ~tx_sh[6];
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        ST_MACK: begin
          if (scl_r) ack_q <= ~sda_s;
          if (scl_f) begin
            if (ack_q && pos < END_READ) begin
              pos   <= pos + PW'(1);
              tx_sh <= reg_rdata;
              oe_q  <= ~reg_rdata[7];
              state <= ST_TX;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/cfgi2c_target_chk.sv
module cfgi2c_target_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_i,
  input logic         sda_oe,
  input logic         start_det,
  input logic         stop_det,
  input logic [N*8-1:0] cfg_o
);

  logic [N*8-1:0] prev_cfg;
  logic           prev_ok;
  logic [N-1:0]   chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cfg <= '0;
      prev_ok  <= 1'b0;
    end else begin
      prev_cfg <= cfg_o;
      prev_ok  <= 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chg
    assign chg[g] = prev_ok && (cfg_o[g*8 +: 8] != prev_cfg[g*8 +: 8]);
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);                            // R10

  AST_COMMIT_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> scl_i);                               // R4

  AST_ONE_REG_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1);                                            // R3

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);                                           // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);                                            // R9

endmodule

bind cfgi2c_target cfgi2c_target_chk #(.N(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .start_det(start_det),
  .stop_det (stop_det),
  .cfg_o    (cfg_o)
);

// File: tb/tb_cfgi2c_target.sv
module tb_cfgi2c_target;

  localparam int N = 6;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] cfg_o;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  cfgi2c_target dut (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_m),
    .sda_i (sda_line),
    .sda_oe(sda_oe),
    .cfg_o (cfg_o)
  );

  int vecs = 0;
  int bad  = 0;
  int r10_viol = 0;
  logic [N*8-1:0] model;

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = !sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = !mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed * 37 + k * 11 + 5);
  endfunction

  // write n data bytes after command and count bytes
  task automatic do_write(input int n, input int seed);
    bit a;
    bus_start;
    wbyte(8'hD2, a);                      chk(a, "R2 write address ack", 48'(a), 48'd1);
    wbyte(8'(8'hA0 ^ seed), a);           chk(a, "R3 command byte ack", 48'(a), 48'd1);
    wbyte(8'(255 - seed), a);             chk(a, "R3 count byte ack", 48'(a), 48'd1);
    chk(cfg_o == model, "R3 cmd/count discarded", cfg_o, model);
    for (int k = 0; k < n; k++) begin
      wbyte(pat(seed, k), a);
      if (k < N) begin
        model[k*8 +: 8] = pat(seed, k);
        chk(a, "R3 data byte ack", 48'(a), 48'd1);
        chk(cfg_o[k*8 +: 8] == pat(seed, k), "R4 byte committed before next",
            48'(cfg_o[k*8 +: 8]), 48'(pat(seed, k)));
      end else begin
        chk(!a, "R5 excess byte nack", 48'(a), 48'd0);
        chk(cfg_o == model, "R5 excess byte not stored", cfg_o, model);
      end
    end
    bus_stop;
    chk(cfg_o == model, "R4 early stop keeps bank", cfg_o, model);
    chk(!sda_oe, "R9 released after stop", 48'(sda_oe), 48'd0);
  endtask

  // read bytes 0..last (0 = count); final one acked per ack_last, then one extra byte
  task automatic do_read(input int last, input bit ack_last);
    bit a;
    logic [7:0] b;
    logic [7:0] e;
    bus_start;
    wbyte(8'hD3, a); chk(a, "R2 read address ack", 48'(a), 48'd1);
    for (int j = 0; j <= last; j++) begin
      rbyte((j < last) ? 1'b1 : ack_last, b);
      e = (j == 0) ? 8'(N) : model[(j-1)*8 +: 8];
      chk(b == e, "R6 read byte", 48'(b), 48'(e));
    end
    rbyte(1'b0, b);
    if (ack_last) chk(b == 8'hFF, "R8 past last register released", 48'(b), 48'hFF);
    else          chk(b == 8'hFF, "R7 released after host nack", 48'(b), 48'hFF);
    bus_stop;
  endtask

  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== $past(sda_oe))) r10_viol++;
  end

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    model = 48'hC3960FF0A53C;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    chk(cfg_o == model, "R1 reset defaults", cfg_o, model);
    chk(!sda_oe, "R1 sda released at reset", 48'(sda_oe), 48'd0);

    do_read(N, 1'b1);                      // R6, R8 on defaults

    for (int n = 0; n <= N + 1; n++) begin // R3 R4 R5 all write lengths
      do_write(n, n + 3);
      do_read(N, 1'b1);
    end

    for (int k = 0; k <= N; k++) do_read(k, 1'b0); // R7 every nack position

    for (int ad = 0; ad < 128; ad++) begin // R2 address sweep
      if (ad == 7'h69) continue;
      for (int rw = 0; rw < 2; rw++) begin
        bus_start;
        wbyte(8'({ad[6:0], rw[0]}), a);
        chk(!a, "R2 foreign address nack", 48'(a), 48'd0);
        if (rw == 0 && ad % 16 == 0) begin
          wbyte(8'h5A, a);
          chk(!a, "R2 ignored until start", 48'(a), 48'd0);
        end
        bus_stop;
      end
    end
    chk(cfg_o == model, "R2 bank untouched by foreign traffic", cfg_o, model);

    // R9 repeated start mid-write restarts at address phase
    bus_start;
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h77, a);
    bus_start;
    wbyte(8'hD2, a); chk(a, "R9 address after repeated start", 48'(a), 48'd1);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h88, a);
    model[7:0] = 8'h88;
    chk(cfg_o == model, "R9 restart writes reg0 again", cfg_o, model);
    bus_start;
    wbyte(8'hD3, a); chk(a, "R9 read after repeated start", 48'(a), 48'd1);
    rbyte(1'b0, b);  chk(b == 8'(N), "R9 count after repeated start", 48'(b), 48'(N));
    bus_stop;
    chk(!sda_oe, "R9 idle after stop", 48'(sda_oe), 48'd0);

    chk(r10_viol == 0, "R10 sda_oe moved while SCL high", 48'(r10_viol), 48'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule